// File: doc/BRIEF.md
# Descriptor-List Peripheral DMA Walker

This block runs a peripheral-bus DMA by walking a chain of command descriptors held in memory. On a start pulse it takes a list base address and reads one header word at a time. The header gives a pattern code, a payload length and a flag that ends the chain. A transfer descriptor also holds a reply destination address and an inline payload. The walker streams that payload to a device port, then writes the device's reply words, or a no-device marker, to the destination. Every other pattern moves the list pointer by a single word. The walker stops after the flagged descriptor. It then reports the total byte count, which the surrounding logic uses to time completion.

The memory side is a single-channel valid/ready request port for 32-bit reads and writes. A read returns its data on a separate valid strobe, one read at a time. The device side has three valid/ready channels: a request channel (recipient and word count), a send-payload stream and a reply stream. Back-pressure rules: a source holds valid and keeps its payload unchanged until the matching ready is sampled high. The walker accepts a reply beat only while it is ready to write the previous one out, so a slow memory port stalls the reply stream. An order-select input, sampled at start, chooses whether payload and reply words are byte-reversed.

Top module: `dlw_walker`

## Requirements
- R1: Header word fields: bit 31 = end-of-chain flag, bits 10:8 = pattern code, bits 7:0 = payload length in words minus one. The walker finishes after processing the descriptor whose flag is set, and busy, memory and device valids stay low while idle.
- R2: Pattern 0 (transfer): the word at header+4 is the reply destination, ANDed with 0x1FFFFFE0; the payload starts at header+8; the next header is at header + 8 + 4*(length field + 1).
- R3: Patterns 2, 3, 4 and 7, and the unassigned codes 1, 5 and 6, fetch only the header and advance the pointer by 4 bytes, with no device traffic and no memory write.
- R4: Pattern 2 produces a one-cycle occupy pulse whose bus number equals header bits 17:16.
- R5: For a transfer, the device request carries recipient = bits 15:8 of the first payload word (after order handling) and word count = length field + 1; exactly that many payload words are streamed, with the last-beat marker on the final one.
- R6: With order-select 0, every payload word sent and every reply word stored is byte-reversed across 32 bits; with order-select 1 they pass unchanged; header and destination words are never reordered.
- R7: Reply beat k is written to destination + 4*k, and nothing past the final reply beat is written.
- R8: A reply beat flagged no-device ends the reply and causes 0xFFFFFFFF to be written to the first destination word; it adds no reply bytes.
- R9: The reported byte count is the sum of 4*(length field + 1) over all descriptors plus 4 per stored reply word.
- R10: done pulses for exactly one cycle per accepted start, with the byte count valid in that cycle; busy is high from the cycle after start acceptance until done and low in the done cycle; start is ignored while busy.
- R11: On every valid/ready output channel, a raised valid stays high with stable payload until ready is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| list_base | input | ADDR_W | Byte address of the first header |
| order_sel | input | 1 | 0 = byte-reverse payload and replies, 1 = pass as is |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| byte_count | output | CNT_W | Total bytes of the finished walk |
| occ_valid | output | 1 | One-cycle occupy-permission pulse |
| occ_bus | output | 2 | Bus number for the occupy pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| dev_req_valid | output | 1 | Device request valid |
| dev_req_ready | input | 1 | Device request accepted |
| dev_req_recip | output | 8 | Recipient address |
| dev_req_words | output | 9 | Payload word count |
| dev_tx_valid | output | 1 | Payload beat valid |
| dev_tx_ready | input | 1 | Payload beat accepted |
| dev_tx_data | output | DATA_W | Payload word |
| dev_tx_last | output | 1 | Final payload beat |
| dev_rx_valid | input | 1 | Reply beat valid |
| dev_rx_ready | output | 1 | Reply beat accepted |
| dev_rx_data | input | DATA_W | Reply word |
| dev_rx_last | input | 1 | Final reply beat |
| dev_rx_nodev | input | 1 | No device at the addressed port |

## Verification
The hardest situation to reach is a full-length transfer (length field 255) that runs while every ready input is throttled and the word order is reversed. Only then do pointer arithmetic, payload indexing and swap handling all hit their extremes at once. The stimulus table places such a list, with a destination word that carries junk in its masked bits, behind a throttled memory port. Each transfer list ends in a no-op descriptor, so a wrong next-header address shows up as a wrong byte count. A separate chain of every non-transfer code checks that each one steps by a single word.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  localparam logic [2:0] PAT_XFER      = 3'd0;
  localparam logic [2:0] PAT_OCC       = 3'd2;
  localparam logic [2:0] PAT_BUS_RESET = 3'd3;
  localparam logic [2:0] PAT_OCC_DROP  = 3'd4;
  localparam logic [2:0] PAT_IDLE      = 3'd7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_HDR_EVAL,
    ST_DST_REQ,
    ST_DST_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_DEV_REQ,
    ST_TX,
    ST_RX,
    ST_WR
  } walk_st_e;

  typedef struct packed {
    logic       last;
    logic [2:0] pat;
    logic [7:0] len_m1;
    logic [1:0] bus;
  } hdr_t;

endpackage

// File: rtl/dlw_hdr_decode.sv
module dlw_hdr_decode
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [31:0]       word,
  output hdr_t              fields,
  output logic              is_xfer,
  output logic [8:0]        nwords,
  output logic [ADDR_W-1:0] step
);
  logic unused_hdr_bits;
  assign unused_hdr_bits = ^{word[30:18], word[15:11]};

  always_comb begin
    fields.last   = word[31];
    fields.pat    = word[10:8];
    fields.len_m1 = word[7:0];
    fields.bus    = word[17:16];
    is_xfer       = (word[10:8] == PAT_XFER);
    nwords        = {1'b0, word[7:0]} + 9'd1;
    step          = is_xfer ? (ADDR_W'(8) + (ADDR_W'(nwords) << 2)) : ADDR_W'(4);
  end
endmodule

// File: rtl/dlw_swap.sv
module dlw_swap #(
  parameter int WORD_W = 32
) (
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NB = WORD_W / 8;
  logic [WORD_W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = din[WORD_W-8-8*b +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/dlw_byte_acc.sv
module dlw_byte_acc #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_val,
  output logic [CNT_W-1:0] acc_q,
  output logic [CNT_W-1:0] acc_next
);
  assign acc_next = acc_q + (add_en ? add_val : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= acc_next;
  end

  // R9: the total only moves when something is added
  a_r9_hold_without_add: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !add_en) |=> $stable(acc_q));
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker
  import dlw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter logic [ADDR_W-1:0] DEST_MASK = ADDR_W'(32'h1FFF_FFE0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              order_sel,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  byte_count,
  output logic              occ_valid,
  output logic [1:0]        occ_bus,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dev_req_valid,
  input  logic              dev_req_ready,
  output logic [7:0]        dev_req_recip,
  output logic [8:0]        dev_req_words,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_last,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_last,
  input  logic              dev_rx_nodev
);
  localparam int IDX_W = 9;

  walk_st_e          st;
  logic [ADDR_W-1:0] ptr_q, dst_q;
  logic [31:0]       hdr_q;
  logic [IDX_W-1:0]  idx_q, rxk_q;
  logic [DATA_W-1:0] word_q, wdata_q;
  logic              rxlast_q, swap_q, done_q, occ_q;
  logic [1:0]        occ_bus_q;
  logic [CNT_W-1:0]  count_q;

  hdr_t              dec;
  logic              dec_xfer;
  logic [8:0]        dec_nwords;
  logic [ADDR_W-1:0] dec_step;

  dlw_hdr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word(hdr_q), .fields(dec), .is_xfer(dec_xfer),
    .nwords(dec_nwords), .step(dec_step)
  );

  logic [DATA_W-1:0] swap_in, swap_out;
  assign swap_in = (st == ST_RX) ? dev_rx_data : mem_rdata;

  dlw_swap #(.WORD_W(DATA_W)) u_swap (
    .en(swap_q), .din(swap_in), .dout(swap_out)
  );

  logic             acc_clear, acc_add;
  logic [CNT_W-1:0] acc_val, acc_q, acc_next;

  always_comb begin
    acc_clear = (st == ST_IDLE) && start;
    acc_add   = 1'b0;
    acc_val   = '0;
    if (st == ST_HDR_EVAL) begin
      acc_add = 1'b1;
      acc_val = CNT_W'(dec_nwords) << 2;
    end else if (st == ST_RX && dev_rx_valid && !dev_rx_nodev) begin
      acc_add = 1'b1;
      acc_val = CNT_W'(4);
    end
  end

  dlw_byte_acc #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear),
    .add_en(acc_add), .add_val(acc_val),
    .acc_q(acc_q), .acc_next(acc_next)
  );

  logic tx_final;
  assign tx_final = (idx_q == (dec_nwords - 9'd1));

  // Request channel outputs are decoded straight from state
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = ptr_q;
    unique case (st)
      ST_HDR_REQ: mem_req_valid = 1'b1;
      ST_DST_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr_q + ADDR_W'(4);
      end
      ST_PAY_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr_q + ADDR_W'(8) + (ADDR_W'(idx_q) << 2);
      end
      ST_WR: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = dst_q + (ADDR_W'(rxk_q) << 2);
      end
      default: ;
    endcase
  end

  assign mem_req_wdata = wdata_q;
  assign dev_req_valid = (st == ST_DEV_REQ);
  assign dev_req_recip = word_q[15:8];
  assign dev_req_words = dec_nwords;
  assign dev_tx_valid  = (st == ST_TX);
  assign dev_tx_data   = word_q;
  assign dev_tx_last   = tx_final;
  assign dev_rx_ready  = (st == ST_RX);
  assign busy          = (st != ST_IDLE);
  assign done          = done_q;
  assign byte_count    = count_q;
  assign occ_valid     = occ_q;
  assign occ_bus       = occ_bus_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ptr_q     <= '0;
      dst_q     <= '0;
      hdr_q     <= '0;
      idx_q     <= '0;
      rxk_q     <= '0;
      word_q    <= '0;
      wdata_q   <= '0;
      rxlast_q  <= 1'b0;
      swap_q    <= 1'b0;
      done_q    <= 1'b0;
      occ_q     <= 1'b0;
      occ_bus_q <= '0;
      count_q   <= '0;
    end else begin
      done_q <= 1'b0;
      occ_q  <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          ptr_q  <= list_base;
          swap_q <= ~order_sel;
          st     <= ST_HDR_REQ;
        end
        ST_HDR_REQ:  if (mem_req_ready) st <= ST_HDR_WAIT;
        ST_HDR_WAIT: if (mem_rvalid) begin
          hdr_q <= mem_rdata;
          st    <= ST_HDR_EVAL;
        end
        ST_HDR_EVAL: begin
          if (dec_xfer) begin
            st <= ST_DST_REQ;
          end else begin
            if (dec.pat == PAT_OCC) begin
              occ_q     <= 1'b1;
              occ_bus_q <= dec.bus;
            end
            ptr_q <= ptr_q + dec_step;
            if (dec.last) begin
              done_q  <= 1'b1;
              count_q <= acc_next;
              st      <= ST_IDLE;
            end else begin
              st <= ST_HDR_REQ;
            end
          end
        end
        ST_DST_REQ:  if (mem_req_ready) st <= ST_DST_WAIT;
        ST_DST_WAIT: if (mem_rvalid) begin
          dst_q <= mem_rdata & DEST_MASK;
          idx_q <= '0;
          st    <= ST_PAY_REQ;
        end
        ST_PAY_REQ:  if (mem_req_ready) st <= ST_PAY_WAIT;
        ST_PAY_WAIT: if (mem_rvalid) begin
          word_q <= swap_out;
          st     <= (idx_q == '0) ? ST_DEV_REQ : ST_TX;
        end
        ST_DEV_REQ: if (dev_req_ready) st <= ST_TX;
        ST_TX: if (dev_tx_ready) begin
          if (tx_final) begin
            rxk_q <= '0;
            st    <= ST_RX;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_PAY_REQ;
          end
        end
        ST_RX: if (dev_rx_valid) begin
          wdata_q  <= dev_rx_nodev ? '1 : swap_out;
          rxlast_q <= dev_rx_nodev | dev_rx_last;
          st       <= ST_WR;
        end
        ST_WR: if (mem_req_ready) begin
          rxk_q <= rxk_q + 1'b1;
          if (rxlast_q) begin
            ptr_q <= ptr_q + dec_step;
            if (dec.last) begin
              done_q  <= 1'b1;
              count_q <= acc_next;
              st      <= ST_IDLE;
            end else begin
              st <= ST_HDR_REQ;
            end
          end else begin
            st <= ST_RX;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: channel stability under back-pressure
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata)));
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_valid && !dev_req_ready) |=> (dev_req_valid && $stable(dev_req_recip)
      && $stable(dev_req_words)));
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid && !dev_tx_ready) |=> (dev_tx_valid && $stable(dev_tx_data)
      && $stable(dev_tx_last)));
  // R10: completion handshake
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1: quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !dev_req_valid && !dev_tx_valid && !dev_rx_ready));
  // R4: occupy strobe is a single cycle
  a_r4_occ_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    occ_valid |=> !occ_valid);
  // R2: first reply word lands on an aligned destination
  a_r2_dest_align: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && rxk_q == '0) |-> (mem_req_addr[4:0] == 5'd0));
  // R8: no-device beat turns into the all-ones marker write
  a_r8_nodev_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rx_valid && dev_rx_ready && dev_rx_nodev) |=>
      (mem_req_valid && mem_req_we && mem_req_wdata == '1));
endmodule

// File: tb/dlw_walker_tb.sv
`timescale 1ns/1ps
module dlw_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0, order_sel = 1'b1;
  logic [31:0] list_base = '0;
  logic        busy, done, occ_valid;
  logic [23:0] byte_count;
  logic [1:0]  occ_bus;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_rvalid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata;
  logic        dev_req_valid, dev_req_ready, dev_tx_valid, dev_tx_ready, dev_tx_last;
  logic [7:0]  dev_req_recip;
  logic [8:0]  dev_req_words;
  logic [31:0] dev_tx_data, dev_rx_data;
  logic        dev_rx_valid, dev_rx_ready, dev_rx_last, dev_rx_nodev;

  dlw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base), .order_sel(order_sel),
    .busy(busy), .done(done), .byte_count(byte_count), .occ_valid(occ_valid), .occ_bus(occ_bus),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_req_recip(dev_req_recip), .dev_req_words(dev_req_words), .dev_tx_valid(dev_tx_valid),
    .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data), .dev_tx_last(dev_tx_last),
    .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready), .dev_rx_data(dev_rx_data),
    .dev_rx_last(dev_rx_last), .dev_rx_nodev(dev_rx_nodev)
  );

  int checks = 0, errors = 0;

  function automatic logic [31:0] rev32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- throttling ----------------
  int  cyc = 0;
  logic bp_en = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_req_ready = !bp_en || (cyc % 3 != 0);
  assign dev_req_ready = !bp_en || (cyc % 2 == 0);
  assign dev_tx_ready  = !bp_en || (cyc % 4 != 1);

  // ---------------- memory model ----------------
  logic [31:0] mem [0:1023];
  int rd_n = 0, wr_n = 0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[11:2]] <= mem_req_wdata;
        wr_n <= wr_n + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_req_addr[11:2]];
        rd_n <= rd_n + 1;
      end
    end
  end

  // ---------------- device model ----------------
  int          cfg_nrep = 1;
  logic        cfg_nodev = 1'b0;
  int          req_n = 0, tx_n = 0, rx_k = 0;
  logic [7:0]  got_recip;
  logic [8:0]  got_words;
  logic [31:0] txbuf [0:255];
  logic        rx_pend = 1'b0, got_txlast = 1'b0;
  function automatic logic [31:0] reply_word(input logic [7:0] rc, input int k);
    return 32'hC0DE_0000 | {16'h0, rc, 8'h0} | 32'(k);
  endfunction
  assign dev_rx_valid = rx_pend;
  assign dev_rx_data  = reply_word(got_recip, rx_k);
  assign dev_rx_nodev = cfg_nodev;
  assign dev_rx_last  = cfg_nodev || (rx_k == cfg_nrep - 1);
  always @(posedge clk) begin
    if (dev_req_valid && dev_req_ready) begin
      got_recip <= dev_req_recip;
      got_words <= dev_req_words;
      req_n <= req_n + 1;
      tx_n  <= 0;
    end
    if (dev_tx_valid && dev_tx_ready) begin
      txbuf[tx_n[7:0]] <= dev_tx_data;
      tx_n <= tx_n + 1;
      got_txlast <= dev_tx_last;
      if (dev_tx_last) begin
        rx_pend <= 1'b1;
        rx_k <= 0;
      end
    end
    if (dev_rx_valid && dev_rx_ready) begin
      if (dev_rx_last) rx_pend <= 1'b0;
      else rx_k <= rx_k + 1;
    end
  end

  // ---------------- output monitors ----------------
  int          done_n = 0, occ_n = 0;
  logic [23:0] seen_count = '0;
  logic [1:0]  seen_bus = '0;
  always @(posedge clk) begin
    if (done) begin
      done_n <= done_n + 1;
      seen_count <= byte_count;
    end
    if (occ_valid) begin
      occ_n <= occ_n + 1;
      seen_bus <= occ_bus;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] hdr(input logic last, input logic [2:0] pat,
                                      input logic [1:0] bus, input logic [7:0] len);
    return {last, 13'h0, bus, 5'h0, pat, len};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic run_walk(input logic [31:0] base, input logic ord);
    int d0;
    d0 = done_n;
    @(negedge clk);
    list_base = base;
    order_sel = ord;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", {31'h0, busy}, 32'h1);
    while (done_n == d0) @(negedge clk);
  endtask

  // vector fields: [31:24] reply words, [23:16] recipient, [15:8] length field,
  // [4] no-device, [1] throttle, [0] order-select
  localparam logic [31:0] CASES [6] = '{
    32'h0320_0301, 32'h0241_0002, 32'h0105_0110,
    32'h0582_0703, 32'h01C0_FF02, 32'h0811_0411
  };
  localparam int BASE_W = 64;     // list at byte 0x100
  localparam int DEST_W = 768;    // destination at byte 0xC00

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10: reset state
    check("R10 reset busy", {31'h0, busy}, 32'h0);
    check("R10 reset done", {31'h0, done}, 32'h0);
    check("R1 reset mem valid", {31'h0, mem_req_valid}, 32'h0);
    check("R1 reset dev valid", {30'h0, dev_req_valid, dev_tx_valid}, 32'h0);
    check("R9 reset count", {8'h0, byte_count}, 32'h0);

    // ---------------- table-driven transfers ----------------
    foreach (CASES[ci]) begin
      logic [7:0] nrep, rc, len;
      logic nd, ord;
      logic [31:0] fh, w;
      int wr0, req0, d0, nwords, stored;
      nrep = CASES[ci][31:24]; rc = CASES[ci][23:16]; len = CASES[ci][15:8];
      nd = CASES[ci][4]; ord = CASES[ci][0];
      bp_en = CASES[ci][1];
      cfg_nrep = int'(nrep); cfg_nodev = nd;
      nwords = int'(len) + 1;
      clear_mem();
      mem[BASE_W]   = hdr(1'b0, 3'd0, 2'd0, len);
      mem[BASE_W+1] = 32'hE000_0C1F;  // R2: masks to 0xC00
      fh = {len, 8'h20, rc, 8'h01};
      for (int i = 0; i < nwords; i++) begin
        w = (i == 0) ? fh : (32'h1000_0000 + 32'(i) * 32'h111);
        mem[BASE_W + 2 + i] = ord ? w : rev32(w);
      end
      mem[BASE_W + 2 + nwords] = hdr(1'b1, 3'd7, 2'd0, 8'd0);
      wr0 = wr_n; req0 = req_n; d0 = done_n;
      run_walk(32'h100, ord);
      repeat (4) @(negedge clk);
      stored = nd ? 0 : int'(nrep);
      check("R9 byte count", {8'h0, seen_count}, 32'(4 * nwords + 4 * stored + 4));
      check("R10 one done", 32'(done_n - d0), 32'd1);
      check("R5 one request", 32'(req_n - req0), 32'd1);
      check("R5 recipient", {24'h0, got_recip}, {24'h0, rc});
      check("R5 word count", {23'h0, got_words}, 32'(nwords));
      check("R5 beats sent", 32'(tx_n), 32'(nwords));
      check("R5 last marker", {31'h0, got_txlast}, 32'h1);
      check("R6 first payload", txbuf[0], fh);
      if (nwords > 1)
        check("R6 final payload", txbuf[nwords-1], 32'h1000_0000 + 32'(nwords-1) * 32'h111);
      if (nd) begin
        check("R8 marker", mem[DEST_W], 32'hFFFF_FFFF);
        check("R8 single write", 32'(wr_n - wr0), 32'd1);
        check("R8 next untouched", mem[DEST_W+1], 32'h0);
      end else begin
        for (int k = 0; k < stored; k++) begin
          w = reply_word(rc, k);
          check("R7 reply word", mem[DEST_W+k], ord ? w : rev32(w));
        end
        check("R7 past end untouched", mem[DEST_W+stored], 32'h0);
      end
    end

    // ---------------- R3/R4: every non-transfer code, one word each ----------------
    begin
      int rd0, wr0, req0, occ0;
      bp_en = 1'b1;
      clear_mem();
      mem[BASE_W+0] = hdr(1'b0, 3'd3, 2'd0, 8'd5);
      mem[BASE_W+1] = hdr(1'b0, 3'd5, 2'd0, 8'd2);
      mem[BASE_W+2] = hdr(1'b0, 3'd2, 2'd3, 8'd0);
      mem[BASE_W+3] = hdr(1'b0, 3'd4, 2'd0, 8'd1);
      mem[BASE_W+4] = hdr(1'b0, 3'd1, 2'd0, 8'd0);
      mem[BASE_W+5] = hdr(1'b0, 3'd6, 2'd0, 8'd0);
      mem[BASE_W+6] = hdr(1'b1, 3'd7, 2'd0, 8'd9);
      rd0 = rd_n; wr0 = wr_n; req0 = req_n; occ0 = occ_n;
      run_walk(32'h100, 1'b1);
      repeat (4) @(negedge clk);
      check("R3 header reads", 32'(rd_n - rd0), 32'd7);
      check("R3 no writes", 32'(wr_n - wr0), 32'd0);
      check("R3 no device traffic", 32'(req_n - req0), 32'd0);
      check("R9 chain count", {8'h0, seen_count}, 32'd96);
      check("R4 one occupy pulse", 32'(occ_n - occ0), 32'd1);
      check("R4 occupy bus", {30'h0, seen_bus}, 32'd3);
    end

    // ---------------- R10: start ignored while busy ----------------
    begin
      int d0;
      bp_en = 1'b1;
      cfg_nrep = 2; cfg_nodev = 1'b0;
      clear_mem();
      mem[BASE_W]   = hdr(1'b0, 3'd0, 2'd0, 8'd1);
      mem[BASE_W+1] = 32'h0000_0C00;
      mem[BASE_W+2] = {8'd1, 8'h20, 8'h33, 8'h01};
      mem[BASE_W+3] = 32'h5555_AAAA;
      mem[BASE_W+4] = hdr(1'b1, 3'd7, 2'd0, 8'd0);
      d0 = done_n;
      @(negedge clk);
      list_base = 32'h100; order_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      list_base = 32'h40; start = 1'b1;   // would walk zero headers if taken
      @(negedge clk);
      start = 1'b0;
      while (done_n == d0) @(negedge clk);
      check("R10 busy low after done", {31'h0, busy}, 32'h0);
      repeat (20) @(negedge clk);
      check("R10 start ignored busy", 32'(done_n - d0), 32'd1);
      check("R10 idle stays idle", {31'h0, busy}, 32'h0);
      check("R9 count of first walk", {8'h0, seen_count}, 32'd20);
      check("R7 second reply", mem[DEST_W+1], reply_word(8'h33, 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule